// File: doc/BRIEF.md
# Dual-Role SPI Controller with Master Demotion

This block is a byte-wide SPI peripheral that a processor drives through a control register, a status register, a data write strobe and a read port. The same 8-bit shift engine serves both roles. As master, the block generates the serial clock from the system clock, using one of four fixed divide ratios. As slave, it brings the external serial clock, data and select into the system clock domain and follows the edges it sees there. Both clock polarities, both clock phases and both bit orders are supported in each role.

When a transfer ends, the received byte is copied to the read buffer. The completion flag in the status register is then set and the interrupt request follows it. A master watches its select input unless that input is ignored. If an external device pulls the select low, the block drops to slave role, clears its master bit, releases the clock and data-out pins, abandons any byte in flight and raises the same flag. Software can then see that bus ownership was taken away.

Top module: `spi_dual_role`

## Requirements
- R1: After reset the control register reads 0x04, the status register reads 0x00, irq is low and no pin output enable is high. Control bits: 7 ignore-select, 6 enable, 5 lsb-first, 4 master, 3 clock idle level, 2 clock phase, 1:0 rate select.
- R2: In master mode the serial clock period is 4, 16, 64 or 128 system clock cycles for rate select 0, 1, 2 or 3.
- R3: With enable and master set, a write to the data port starts a transfer of exactly 8 serial clock cycles. The written byte goes out on mosi, the byte sampled from miso is returned on the read port, and the serial clock then returns to its idle level.
- R4: With lsb-first at 0 the most significant bit goes first; with it at 1 the least significant bit goes first. This holds for both sending and receiving.
- R5: The serial clock idles at the level of control bit 3. With phase 0, data is sampled on the first (leading) edge of each clock and changes on the trailing edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R6: At the end of a byte, status bit 7 is set and irq is high. A status write with a 1 to bit 7 clears both.
- R7: In slave mode with enable set and select low, a byte loaded earlier through the data port is shifted out on miso. The byte on mosi is received into the read port, using edges of the synchronized serial clock, and the flag is set.
- R8: A master whose select input is watched and seen low clears its master bit, sets status bit 7, and stops driving sclk and mosi within 4 clock cycles of the low reaching the input. The aborted transfer never completes.
- R9: The select input is ignored, and the block stays master, when the ignore-select bit is 1 or when ss_pin_is_out is high.
- R10: With enable at 0, no pin is driven, a data write starts nothing and the flag stays clear.
- R11: A master drives sclk and mosi but not miso. A selected slave drives only miso.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_q | output | 8 | Control register contents |
| stat_wr | input | 1 | Status register write strobe |
| stat_flag_w | input | 1 | Value written to status bit 7; 1 clears the flag |
| stat_q | output | 8 | Status register, bit 7 is the completion flag |
| dat_wr | input | 1 | Data port write strobe |
| dat_wdata | input | 8 | Byte to send |
| dat_rdata | output | 8 | Last byte received |
| irq | output | 1 | Interrupt request, follows the flag |
| sclk_in | input | 1 | Serial clock from the pin (slave) |
| sclk_out | output | 1 | Serial clock to the pin (master) |
| sclk_oe | output | 1 | Serial clock pin drive enable |
| mosi_in | input | 1 | Master-out data from the pin (slave) |
| mosi_out | output | 1 | Master-out data to the pin |
| mosi_oe | output | 1 | Master-out pin drive enable |
| miso_in | input | 1 | Master-in data from the pin (master) |
| miso_out | output | 1 | Master-in data to the pin (slave) |
| miso_oe | output | 1 | Master-in pin drive enable |
| ss_in | input | 1 | Select input, active low |
| ss_pin_is_out | input | 1 | High when the select pin is set up as an output |

## Verification
A wrong bit counter or a lost pending-shift state shows up as a flag that rises an edge early or late. It can also show as a serial clock left off its idle level, or as a read byte or a captured mosi byte that is off by one bit position, all visible within one byte time. A wrong role state shows up within a few cycles of a select change: a master bit still set, pin enables still on, or a flag that never rises. Divider faults show as a wrong serial clock period, already at the second rising edge.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  localparam int CTL_W  = 8;
  localparam int B_SIGN = 7;
  localparam int B_EN   = 6;
  localparam int B_LSB  = 5;
  localparam int B_MST  = 4;
  localparam int B_POL  = 3;
  localparam int B_PHA  = 2;
  localparam logic [CTL_W-1:0] CTL_RST = 8'h04;

  // half of the serial clock period, in system clock cycles
  function automatic int unsigned half_period(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 8;
      2'd2:    return 32;
      default: return 64;
    endcase
  endfunction
endpackage

// File: rtl/spi_dr_prescale.sv
module spi_dr_prescale #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  import spi_dr_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = CNT_W'(half_period(rate) - 1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R2: each half period spans at least two cycles
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/spi_dr_sync.sv
module spi_dr_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         st[g] <= INIT;
      else if (g == 0) st[g] <= d;
      else             st[g] <= st[(g > 0) ? g-1 : 0];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_dr_shifter.sv
module spi_dr_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          abort,
  input  logic          lsb_first,
  input  logic          late_shift,
  input  logic          smp_ev,
  input  logic          sh_ev,
  input  logic          sin,
  output logic          sout,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] rx_data
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sr;
  logic [DW-1:0] shifted;
  logic          rxb;
  logic          pend;
  logic [CW-1:0] bits;
  logic          full;

  assign shifted = lsb_first ? {rxb, sr[DW-1:1]} : {sr[DW-2:0], rxb};
  assign sout    = lsb_first ? sr[0] : sr[DW-1];
  assign idle    = (bits == '0) && !pend;
  assign full    = (bits == CW'(DW)) && (late_shift || !pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      rxb     <= 1'b0;
      pend    <= 1'b0;
      bits    <= '0;
      done    <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sr   <= ld_data;
        bits <= '0;
        pend <= 1'b0;
      end else if (abort) begin
        bits <= '0;
        pend <= 1'b0;
      end else if (full) begin
        if (pend) sr <= shifted;
        rx_data <= pend ? shifted : sr;
        done    <= 1'b1;
        bits    <= '0;
        pend    <= 1'b0;
      end else if (smp_ev) begin
        rxb  <= sin;
        pend <= 1'b1;
        bits <= bits + 1'b1;
      end else if (sh_ev && pend) begin
        sr   <= shifted;
        pend <= 1'b0;
      end
    end
  end

  // R3: never more than one byte of samples
  a_r3_bits_bound: assert property (@(posedge clk) disable iff (rst)
    bits <= CW'(DW));
endmodule

// File: rtl/spi_dual_role.sv
module spi_dual_role #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_q,
  input  logic          stat_wr,
  input  logic          stat_flag_w,
  output logic [7:0]    stat_q,
  input  logic          dat_wr,
  input  logic [DW-1:0] dat_wdata,
  output logic [DW-1:0] dat_rdata,
  output logic          irq,
  input  logic          sclk_in,
  output logic          sclk_out,
  output logic          sclk_oe,
  input  logic          mosi_in,
  output logic          mosi_out,
  output logic          mosi_oe,
  input  logic          miso_in,
  output logic          miso_out,
  output logic          miso_oe,
  input  logic          ss_in,
  input  logic          ss_pin_is_out
);
  import spi_dr_pkg::*;

  localparam int EDGES = 2 * DW;
  localparam int EC_W  = $clog2(EDGES + 1);

  logic [7:0] ctl;
  logic en, mst, pol, pha, lsb, sign;
  assign en   = ctl[B_EN];
  assign mst  = ctl[B_MST];
  assign pol  = ctl[B_POL];
  assign pha  = ctl[B_PHA];
  assign lsb  = ctl[B_LSB];
  assign sign = ctl[B_SIGN];

  // pin synchronizers
  logic ss_s, mosi_s, sclk_s, sclk_d;
  spi_dr_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({ss_in, mosi_in, sclk_in}),
    .q({ss_s, mosi_s, sclk_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  // role and select decode
  logic watch, dem, sel, slv_act;
  assign watch   = en && !sign && !(mst && ss_pin_is_out);
  assign dem     = watch && mst && !ss_s;
  assign sel     = sign || !ss_s;
  assign slv_act = en && !mst && sel;

  // master clock generation
  logic            busy, m_tick, sclk_int;
  logic [EC_W-1:0] ec;
  logic            m_run;
  assign m_run = busy && (ec < EC_W'(EDGES));

  spi_dr_prescale #(.CNT_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(m_run), .rate(ctl[1:0]), .tick(m_tick)
  );

  // edge events for the shift engine
  logic m_lead, m_trail, s_edge, s_lead, s_trail;
  logic lead, trail, smp_ev, sh_ev, sin;
  assign m_lead  = m_run && m_tick && !ec[0];
  assign m_trail = m_run && m_tick &&  ec[0];
  assign s_edge  = slv_act && (sclk_s != sclk_d);
  assign s_lead  = s_edge && (sclk_d == pol);
  assign s_trail = s_edge && (sclk_d != pol);
  assign lead    = mst ? m_lead  : s_lead;
  assign trail   = mst ? m_trail : s_trail;
  assign smp_ev  = pha ? trail : lead;
  assign sh_ev   = pha ? lead  : trail;
  assign sin     = mst ? miso_in : mosi_s;

  logic start, sload, load, abort, sh_idle, sh_done, sout;
  assign start = dat_wr && en && mst && !busy && !dem;
  assign sload = dat_wr && en && !mst && sh_idle;
  assign load  = start || sload;
  assign abort = dem || !en || (!mst && !sel);

  spi_dr_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load(load), .ld_data(dat_wdata),
    .abort(abort), .lsb_first(lsb), .late_shift(pha),
    .smp_ev(smp_ev), .sh_ev(sh_ev), .sin(sin),
    .sout(sout), .idle(sh_idle), .done(sh_done), .rx_data(dat_rdata)
  );

  // master sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ec       <= '0;
      sclk_int <= 1'b0;
    end else begin
      if (dem || !en || !mst || sh_done) busy <= 1'b0;
      else if (start)                    busy <= 1'b1;

      if (start)       ec <= '0;
      else if (m_run && m_tick) ec <= ec + 1'b1;

      if (!busy || !mst || dem)   sclk_int <= pol;
      else if (m_run && m_tick)   sclk_int <= ~sclk_int;
    end
  end

  // control and status registers
  logic flag;
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl  <= CTL_RST;
      flag <= 1'b0;
    end else begin
      if (ctl_wr) ctl <= ctl_wdata;
      if (dem)    ctl[B_MST] <= 1'b0;

      if (sh_done || dem)          flag <= 1'b1;
      else if (stat_wr && stat_flag_w) flag <= 1'b0;
    end
  end

  // pin drive enables
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_oe <= 1'b0;
      mosi_oe <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      sclk_oe <= en && mst;
      mosi_oe <= en && mst;
      miso_oe <= en && !mst && sel;
    end
  end

  assign ctl_q    = ctl;
  assign stat_q   = {flag, 7'b0};
  assign irq      = flag;
  assign sclk_out = sclk_int;
  assign mosi_out = sout;
  assign miso_out = sout;

  // R8: demotion clears the master bit and raises the flag
  a_r8_demote: assert property (@(posedge clk) disable iff (rst)
    dem |=> (!ctl[B_MST] && flag));

  // R6: a finished byte raises the flag
  a_r6_done_flag: assert property (@(posedge clk) disable iff (rst)
    sh_done |=> flag);

  // R10: a disabled block drives nothing
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en)) |-> (!sclk_oe && !mosi_oe && !miso_oe));

  // R11: the two roles never drive together
  a_r11_roles: assert property (@(posedge clk) disable iff (rst)
    sclk_oe |-> !miso_oe);
endmodule

// File: tb/spi_dual_role_test.sv
module spi_dual_role_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       ctl_wr = 0, stat_wr = 0, stat_flag_w = 0, dat_wr = 0;
  logic [7:0] ctl_wdata = 0, dat_wdata = 0;
  logic [7:0] ctl_q, stat_q, dat_rdata;
  logic       irq;
  logic       sclk_in = 0, mosi_in = 0, miso_in = 0, ss_in = 1, ss_pin_is_out = 0;
  logic       sclk_out, sclk_oe, mosi_out, mosi_oe, miso_out, miso_oe;

  spi_dual_role uut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .stat_wr(stat_wr), .stat_flag_w(stat_flag_w), .stat_q(stat_q),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .irq(irq),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
    .ss_in(ss_in), .ss_pin_is_out(ss_pin_is_out)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bit_at(input logic [7:0] v, input int i, input bit lsb);
    return lsb ? v[i] : v[7-i];
  endfunction

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_wr = 1; dat_wdata = v;
    @(negedge clk); dat_wr = 0;
  endtask

  task automatic clr_flag();
    @(negedge clk); stat_wr = 1; stat_flag_w = 1;
    @(negedge clk); stat_wr = 0; stat_flag_w = 0;
  endtask

  // scoreboard: expected read bytes, compared when irq rises
  logic [7:0] expq[$];
  bit   mon_on = 0;
  logic irq_q = 0;
  always @(negedge clk) begin
    if (mon_on && irq && !irq_q) begin
      if (expq.size() == 0) chk(0, "R6 completion without transfer", 1, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(dat_rdata == e, "R3 R7 read port byte", dat_rdata, e);
      end
    end
    irq_q = irq;
  end

  // slave-side model facing the master outputs
  bit         m_on = 0;
  bit         mc_pol, mc_pha, m_lsb;
  logic [7:0] m_tx, m_cap;
  int         out_idx, cap_idx, last_rise, per;
  logic       prev_sclk;
  always @(negedge clk) begin
    if (m_on && sclk_oe) begin
      if (sclk_out != prev_sclk) begin
        if (sclk_out) begin
          if (last_rise >= 0) per = cyc - last_rise;
          last_rise = cyc;
        end
        if (prev_sclk == mc_pol) begin
          if (!mc_pha) begin
            if (cap_idx < 8) m_cap[m_lsb ? cap_idx : 7-cap_idx] = mosi_out;
            cap_idx++;
          end else begin
            if (out_idx < 8) miso_in = bit_at(m_tx, out_idx, m_lsb);
            out_idx++;
          end
        end else begin
          if (!mc_pha) begin
            out_idx++;
            if (out_idx < 8) miso_in = bit_at(m_tx, out_idx, m_lsb);
          end else begin
            if (cap_idx < 8) m_cap[m_lsb ? cap_idx : 7-cap_idx] = mosi_out;
            cap_idx++;
          end
        end
      end
      prev_sclk = sclk_out;
    end
  end

  task automatic master_xfer(input logic [1:0] rate, input bit pol, input bit pha,
                             input bit lsb, input logic [7:0] tx, input logic [7:0] rx,
                             input int exp_per);
    mc_pol = pol; mc_pha = pha; m_lsb = lsb; m_tx = rx; m_cap = 0;
    out_idx = 0; cap_idx = 0; last_rise = -1; per = 0; prev_sclk = pol;
    miso_in = pha ? 1'b0 : bit_at(rx, 0, lsb);
    wr_ctl({1'b0, 1'b1, lsb, 1'b1, pol, pha, rate});
    repeat (3) @(negedge clk);
    chk(sclk_oe && mosi_oe && !miso_oe, "R11 master pin drive", {sclk_oe, mosi_oe, miso_oe}, 3'b110);
    m_on = 1;
    expq.push_back(rx);
    wr_dat(tx);
    while (!irq) @(negedge clk);
    @(negedge clk);
    m_on = 0;
    chk(m_cap == tx, "R3 R4 byte seen on mosi", m_cap, tx);
    chk(per == exp_per, "R2 serial clock period", per, exp_per);
    chk(cap_idx == 8, "R3 R5 clock edge count", cap_idx, 8);
    chk(sclk_out == pol, "R5 idle level after transfer", sclk_out, pol);
    chk(stat_q == 8'h80, "R6 flag set", stat_q, 8'h80);
    clr_flag();
    chk(stat_q == 8'h00 && !irq, "R6 flag cleared", {stat_q, irq}, 0);
  endtask

  localparam int H = 20;
  task automatic slave_xfer(input bit pol, input bit pha, input bit lsb,
                            input logic [7:0] pre, input logic [7:0] mtx);
    logic [7:0] cap;
    cap = 0;
    ss_in = 1; sclk_in = pol; mosi_in = 0;
    wr_ctl({1'b0, 1'b1, lsb, 1'b0, pol, pha, 2'b00});
    repeat (4) @(negedge clk);
    wr_dat(pre);
    expq.push_back(mtx);
    ss_in = 0;
    for (int i = 0; i < 8; i++) begin
      if (!pha) begin
        mosi_in = bit_at(mtx, i, lsb);
        repeat (H) @(negedge clk);
        cap[lsb ? i : 7-i] = miso_out;
        sclk_in = ~pol;
        repeat (H) @(negedge clk);
        sclk_in = pol;
      end else begin
        repeat (H) @(negedge clk);
        sclk_in = ~pol;
        mosi_in = bit_at(mtx, i, lsb);
        repeat (H) @(negedge clk);
        cap[lsb ? i : 7-i] = miso_out;
        sclk_in = pol;
      end
    end
    repeat (H) @(negedge clk);
    chk(miso_oe && !sclk_oe && !mosi_oe, "R11 slave pin drive", {sclk_oe, mosi_oe, miso_oe}, 3'b001);
    chk(cap == pre, "R7 R4 byte seen on miso", cap, pre);
    chk(stat_q[7], "R7 flag after slave byte", stat_q, 8'h80);
    ss_in = 1;
    repeat (4) @(negedge clk);
    clr_flag();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog expired actual=%0d expected=done", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ctl_q == 8'h04, "R1 control reset", ctl_q, 8'h04);
    chk(stat_q == 8'h00 && !irq, "R1 status reset", {stat_q, irq}, 0);
    chk(!sclk_oe && !mosi_oe && !miso_oe, "R1 no pin driven", {sclk_oe, mosi_oe, miso_oe}, 0);

    // R10: disabled block does nothing
    wr_ctl(8'h10);
    wr_dat(8'h3C);
    repeat (300) @(negedge clk);
    chk(stat_q == 8'h00, "R10 no transfer when disabled", stat_q, 0);
    chk(!sclk_oe && !mosi_oe && !miso_oe, "R10 pins released", {sclk_oe, mosi_oe, miso_oe}, 0);

    mon_on = 1;
    master_xfer(2'd0, 0, 0, 0, 8'hA6, 8'h35, 4);
    master_xfer(2'd1, 1, 0, 1, 8'h1E, 8'hC9, 16);
    master_xfer(2'd2, 0, 1, 0, 8'h4B, 8'h92, 64);
    master_xfer(2'd3, 1, 1, 1, 8'hD1, 8'h6C, 128);

    slave_xfer(0, 0, 0, 8'h5A, 8'hE3);
    slave_xfer(1, 1, 1, 8'h87, 8'h2D);

    // R9: select ignored by the ignore bit
    mon_on = 0;
    ss_in = 1;
    wr_ctl(8'hD3);
    ss_in = 0;
    repeat (6) @(negedge clk);
    chk(ctl_q[4] && stat_q == 8'h00, "R9 ignore bit keeps master", {ctl_q[4], stat_q[7]}, 2'b10);
    ss_in = 1;
    // R9: select pin set as output
    wr_ctl(8'h53);
    ss_pin_is_out = 1;
    repeat (2) @(negedge clk);
    ss_in = 0;
    repeat (6) @(negedge clk);
    chk(ctl_q[4] && stat_q == 8'h00, "R9 output select keeps master", {ctl_q[4], stat_q[7]}, 2'b10);
    ss_in = 1;
    repeat (4) @(negedge clk);
    ss_pin_is_out = 0;

    // R8: demotion during a transfer
    wr_ctl(8'h53);
    repeat (3) @(negedge clk);
    wr_dat(8'hA5);
    repeat (40) @(negedge clk);
    chk(sclk_oe && stat_q == 8'h00, "R8 transfer running", {sclk_oe, stat_q[7]}, 2'b10);
    ss_in = 0;
    repeat (5) @(negedge clk);
    chk(!ctl_q[4], "R8 master bit cleared", ctl_q[4], 0);
    chk(stat_q == 8'h80 && irq, "R8 flag raised", {stat_q[7], irq}, 2'b11);
    chk(!sclk_oe && !mosi_oe && miso_oe, "R8 R11 pins after demotion", {sclk_oe, mosi_oe, miso_oe}, 3'b001);
    ss_in = 1;
    repeat (4) @(negedge clk);
    clr_flag();
    repeat (1200) @(negedge clk);
    chk(stat_q == 8'h00, "R8 aborted byte never completes", stat_q, 0);
    chk(expq.size() == 0, "R6 every transfer completed", expq.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule